// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Divider

This block derives the bit clock of a synchronous serial master from its parent clock. A 16-bit clock-select word carries two fields: a 5-bit prescaler and a 3-bit power-of-two divider code. The total ratio N, in parent cycles per serial-clock period, is the prescale value times the selected divider. N ranges from 1 to 1024.

The block has two outputs. The first is the serial clock level. The second is a one-cycle tick that marks each serial-clock edge, so it runs at twice the serial rate; a downstream shift engine uses it to launch and capture data. A new clock-select word can be written at any time. While the clock runs, the new word is held and only takes effect at the next period boundary, so a reconfiguration never produces a short pulse. Dropping the run enable parks the clock at its low idle level and restarts the period count. Choosing a word from a target frequency is left to the caller.

Top module: `sclk_div_top`

## Requirements
- R1: The prescale value is the clock-select field at bits 12:8 plus one, giving 1 to 32. Bits 15:13 and 7:3 of the word have no effect on either output.
- R2: Divider codes in bits 2:0 select the second stage as follows: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 16, 4 gives 32.
- R3: Divider code 7 selects divide by one. With a total ratio of 1, the clock output equals the parent clock gated by the registered run state, and the tick is high on every running cycle.
- R4: Divider codes 5 and 6 behave exactly as code 0 (divide by 2).
- R5: The serial period is N = prescale × divider parent cycles, up to 1024. For N > 1, the clock is high for the first N − floor(N/2) cycles of each period and low for the rest.
- R6: For N > 1, the tick is high for one cycle at the first cycle of each period and at the first low cycle. It is low otherwise.
- R7: The run enable is registered. While that registered state is low, the clock and the tick are low and the period count is held at its start. The first cycle after run enable is sampled high is the first cycle of a period.
- R8: A write accepted while running changes the ratio only from the first cycle of the next period; the period in progress completes with the old ratio. A write accepted while stopped takes effect at the next start.
- R9: After reset the outputs are low and the active word is 0x0000, giving a ratio of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wdata | input | 16 | Clock-select word |
| cfg_we | input | 1 | Write strobe for cfg_wdata |
| run_en | input | 1 | Run enable |
| sclk_o | output | 1 | Serial clock level, idle low |
| bit_tick_o | output | 1 | Edge tick at twice the serial rate |

## Verification
A wrong period count or a wrong decoded ratio shows up at the ports within one serial period. The tick fires in the wrong cycle, and the clock's high/low split moves. A ratio that is reloaded at the wrong moment shows up as a stretched or shortened period right after a write. The cycle-accurate reference sees this at the first cycle after the boundary. A stale run state shows up as a tick or a high level in the cycle right after run enable falls. Divide by one is also sampled with the parent clock low, which exposes a gated clock that is stuck high.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int CFG_W     = 16;
  localparam int PRE_LSB   = 8;
  localparam int PRE_W     = 5;
  localparam int SEL_W     = 3;
  localparam int SEL_MAXSH = 5;
  localparam int RATIO_MAX = (1 << PRE_W) * (1 << SEL_MAXSH);
  localparam int RATIO_W   = $clog2(RATIO_MAX + 1);
  localparam int CNT_W     = $clog2(RATIO_MAX);

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [CNT_W-1:0]   count_t;

  // shift amount of the second stage for a divider code
  function automatic logic [2:0] sel_shift(input logic [SEL_W-1:0] code);
    logic [2:0] sh;
    case (code)
      3'd0:    sh = 3'd1;
      3'd1:    sh = 3'd2;
      3'd2:    sh = 3'd3;
      3'd3:    sh = 3'd4;
      3'd4:    sh = 3'd5;
      3'd7:    sh = 3'd0;
      default: sh = 3'd1;  // reserved codes run as divide by 2
    endcase
    return sh;
  endfunction

  function automatic ratio_t decode_ratio(input logic [CFG_W-1:0] word);
    ratio_t pre;
    pre = ratio_t'(word[PRE_LSB +: PRE_W]) + ratio_t'(1);
    return pre << sel_shift(word[SEL_W-1:0]);
  endfunction
endpackage

// File: rtl/sclk_div_cfg.sv
module sclk_div_cfg
  import sclk_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             load,
  output ratio_t           ratio_o
);
  ratio_t pend_q, pend_d;
  ratio_t act_q, act_d;

  always_comb begin
    pend_d = pend_q;
    if (wr_en) pend_d = decode_ratio(wr_data);
    act_d = act_q;
    if (load) act_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= decode_ratio('0);
      act_q  <= decode_ratio('0);
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign ratio_o = act_q;
endmodule

// File: rtl/sclk_div_phase.sv
module sclk_div_phase
  import sclk_div_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run_en,
  input  ratio_t ratio_i,
  output logic   load_o,
  output logic   live_o,
  output count_t cnt_o,
  output logic   sclk_o,
  output logic   tick_o
);
  logic   live_q, live_d;
  count_t cnt_q, cnt_d;
  ratio_t hi_len;
  ratio_t cnt_ext;
  logic   at_last;
  logic   unity;

  assign cnt_ext = ratio_t'(cnt_q);
  assign hi_len  = ratio_i - (ratio_i >> 1);
  assign at_last = (cnt_ext == ratio_i - ratio_t'(1));
  assign unity   = (ratio_i == ratio_t'(1));

  always_comb begin
    live_d = run_en;
    cnt_d  = '0;
    if (run_en && live_q && !at_last) cnt_d = cnt_q + count_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      live_q <= live_d;
      cnt_q  <= cnt_d;
    end
  end

  assign load_o = !live_q || at_last;
  assign live_o = live_q;
  assign cnt_o  = cnt_q;
  assign sclk_o = live_q && (unity ? clk : (cnt_ext < hi_len));
  assign tick_o = live_q && (unity || cnt_q == '0 || cnt_ext == hi_len);
endmodule

// File: rtl/sclk_div_top.sv
module sclk_div_top
  import sclk_div_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_wdata,
  input  logic        cfg_we,
  input  logic        run_en,
  output logic        sclk_o,
  output logic        bit_tick_o
);
  ratio_t act_ratio;
  count_t phase_cnt;
  logic   phase_live;
  logic   reload;

  sclk_div_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .load    (reload),
    .ratio_o (act_ratio)
  );

  sclk_div_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .ratio_i (act_ratio),
    .load_o  (reload),
    .live_o  (phase_live),
    .cnt_o   (phase_cnt),
    .sclk_o  (sclk_o),
    .tick_o  (bit_tick_o)
  );
endmodule

// File: rtl/sclk_div_chk.sv
module sclk_div_chk
  import sclk_div_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   run_en,
  input logic   bit_tick,
  input ratio_t ratio,
  input count_t cnt,
  input logic   live
);
  // R7: a stopped run state yields no tick and a held count
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_en) |-> (!bit_tick && cnt == '0));

  // R8: the active ratio changes only on the first cycle of a period
  assert_reload_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(live) && ratio != $past(ratio)) |-> cnt == '0);

  // R5: the count stays inside the active period
  assert_count_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (ratio_t'(cnt) < ratio));

  // R5: the ratio stays within 1..1024
  assert_ratio_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != '0) && (ratio <= ratio_t'(RATIO_MAX)));

  // R6: the tick at a period start is single when N >= 3
  assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ratio >= ratio_t'(3) && cnt == '0) |=> !bit_tick);
endmodule

bind sclk_div_top sclk_div_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .bit_tick (bit_tick_o),
  .ratio    (act_ratio),
  .cnt      (phase_cnt),
  .live     (phase_live)
);

// File: tb/sim_sclk_div_top.sv
module sim_sclk_div_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_wdata;
  logic        cfg_we;
  logic        run_en;
  logic        sclk_o;
  logic        bit_tick_o;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string tag    = "R9";

  int m_pend, m_act, m_cnt, m_live;

  always #10 clk = ~clk;

  sclk_div_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we),
    .run_en(run_en), .sclk_o(sclk_o), .bit_tick_o(bit_tick_o)
  );

  function automatic int ratio_of(input logic [15:0] w);
    int p, d;
    p = int'(w[12:8]) + 1;
    if (w[2:0] == 3'd7) d = 1;
    else if (w[2:0] <= 3'd4) d = 2 ** (int'(w[2:0]) + 1);
    else d = 2;
    return p * d;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // cycle-by-cycle reference
  always @(posedge clk) begin
    int n_pend, n_act, n_cnt, n_live, es, et, hi;
    if (!rst_n) begin
      m_pend = 2; m_act = 2; m_cnt = 0; m_live = 0;
    end else begin
      n_pend = cfg_we ? ratio_of(cfg_wdata) : m_pend;
      n_act  = (!m_live || m_cnt == m_act - 1) ? m_pend : m_act;
      n_cnt  = (run_en && m_live && m_cnt != m_act - 1) ? m_cnt + 1 : 0;
      n_live = run_en ? 1 : 0;
      m_pend = n_pend; m_act = n_act; m_cnt = n_cnt; m_live = n_live;
    end
    #5;
    hi = m_act - m_act / 2;
    if (m_live == 0) begin es = 0; et = 0; end
    else if (m_act == 1) begin es = 1; et = 1; end
    else begin
      es = (m_cnt < hi) ? 1 : 0;
      et = (m_cnt == 0 || m_cnt == hi) ? 1 : 0;
    end
    if (!done) begin
      check(sclk_o == es[0], "sclk", int'(sclk_o), es);
      check(bit_tick_o == et[0], "tick", int'(bit_tick_o), et);
    end
  end

  task automatic wr(input logic [15:0] v);
    @(negedge clk); cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic run_word(input logic [15:0] v, input int cycles);
    @(negedge clk); run_en = 1'b0;
    wr(v);
    run_en = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(sclk_o == 1'b0 && bit_tick_o == 1'b0, "reset outputs", int'(sclk_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_en = 1'b1;
    repeat (12) @(negedge clk);
    // R2: codes 0..4
    tag = "R2";
    for (int c = 0; c < 5; c++) run_word(16'(c), 3 * (2 << c) + 4);
    // R1: prescaler field with noise in unused bits
    tag = "R1";
    run_word(16'hE2F9, 40);
    run_word(16'h0407, 20);
    // R5: largest ratio
    tag = "R5";
    run_word(16'hFF04, 2100);
    // R3: divide by one
    tag = "R3";
    run_word(16'h0007, 10);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #5;
      check(sclk_o == 1'b0, "sclk with parent clock low", int'(sclk_o), 0);
    end
    // R4: reserved codes
    tag = "R4";
    run_word(16'h0005, 10);
    run_word(16'h0306, 30);
    // R6: odd ratio 3
    tag = "R6";
    run_word(16'h0207, 20);
    // R8: writes while running
    tag = "R8";
    run_word(16'h0002, 5);
    for (int k = 0; k < 10; k++) begin
      repeat (k + 1) @(negedge clk);
      wr((k % 2 == 0) ? 16'h0102 : 16'h0001);
    end
    repeat (40) @(negedge clk);
    // R7: stop and restart mid-period
    tag = "R7";
    run_word(16'h0202, 9);
    run_en = 1'b0;
    repeat (5) @(negedge clk);
    run_en = 1'b1;
    repeat (30) @(negedge clk);
    run_en = 1'b0;
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule